// File: doc/BRIEF.md
# Flash Busy Status and Erase Timer

This block produces the status byte that a parallel NOR flash presents while it is busy with an embedded program or erase operation. It also measures how long an erase takes. A command sequencer sends it single-cycle start pulses for a word program, a sector erase or a whole-array erase, along with the top bit of the word being programmed. The block holds the status byte that the sequencer returns on reads while an operation runs. When the operation ends, the block raises a completion pulse. The sequencer uses that pulse to go back to array-read mode, or to its command cycle if unlock bypass is on.

A program operation finishes at once: its status is fixed in the cycle after the start, and the completion pulse follows straight away. An erase clears the status byte and starts a down-counter. Sector erase and whole-array erase each have their own duration, set by parameters and counted in clock cycles. While the counter runs, every status read inverts bit 6 after the read, so software polling the byte sees that bit toggle. When the counter expires, bit 7 is inverted.

Top module: `flash_busy_status`

## Requirements
- R1: After reset, `status_out` is 0x00, and `busy`, `done` and `done_bypass` are all 0.
- R2: An accepted sector or whole-array erase start raises `busy` and sets `status_out` to 0x00 in the next cycle.
- R3: While `busy` is 1, each cycle with `status_rd` high inverts status bit 6 (value 0x40) on the next edge. While idle, `status_rd` leaves the status byte unchanged.
- R4: A sector erase keeps `busy` high for exactly SECT_CYCLES cycles.
- R5: A whole-array erase keeps `busy` high for exactly CHIP_CYCLES cycles.
- R6: When an erase completes, `busy` falls, status bit 7 (value 0x80) is inverted, and `done` is high for exactly one cycle.
- R7: An accepted program start leaves `busy` at 0. In the next cycle it sets `status_out` to 0x7F when `prog_msb` is 1, or to 0xFF when `prog_msb` is 0, and `done` is high for one cycle.
- R8: `done_bypass` is high only together with `done`. It is high exactly when `bypass_en` was high on the completing edge, which is the start edge for a program and the expiry edge for an erase.
- R9: Any start pulse arriving while `busy` is 1 is ignored: the erase duration and status bits 7 and 5..0 are unchanged.
- R10: When several starts arrive together while idle, whole-array erase wins over sector erase, and sector erase wins over program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_prog | input | 1 | Program start pulse |
| start_sect | input | 1 | Sector erase start pulse |
| start_chip | input | 1 | Whole-array erase start pulse |
| prog_msb | input | 1 | Bit 7 of the programmed data |
| bypass_en | input | 1 | Unlock bypass is active in the sequencer |
| status_rd | input | 1 | Status byte is being read this cycle |
| status_out | output | 8 | Registered status byte |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| done_bypass | output | 1 | Completion pulse that returns to the command cycle |

## Verification
The bench builds the block with SECT_CYCLES=5 and CHIP_CYCLES=12. With these values every erase can be followed cycle by cycle to its exact end, and the bench can compare the bit 6 parity against a count of reads. It sweeps three read patterns across both erase kinds and both bypass settings. It runs every combination of data bit and bypass setting for a program. It injects starts in the middle of an erase and raises simultaneous starts, so the ignore rule and the priority order are both reached in short runs.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int STAT_W     = 8;
  localparam int TOGGLE_BIT = 6;
  localparam int DONE_BIT   = 7;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;
endpackage

// File: rtl/fbs_op_pick.sv
module fbs_op_pick
  import fbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_prog,
  input  logic start_sect,
  input  logic start_chip,
  input  logic busy,
  output op_e  op
);
  always_comb begin
    op = OP_NONE;
    if (!busy) begin
      if (start_chip)      op = OP_CHIP;
      else if (start_sect) op = OP_SECT;
      else if (start_prog) op = OP_PROG;
    end
  end

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (op == OP_NONE));
  p_chip_first_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_chip) |-> (op == OP_CHIP));
endmodule

// File: rtl/fbs_erase_timer.sv
module fbs_erase_timer
  import fbs_pkg::*;
#(
  parameter int SECT_CYCLES = 25_000_000,
  parameter int CHIP_CYCLES = 250_000_000
) (
  input  logic clk,
  input  logic rst,
  input  op_e  op,
  output logic busy,
  output logic expire
);
  localparam int MAX_CYC = (CHIP_CYCLES > SECT_CYCLES) ? CHIP_CYCLES : SECT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;
  localparam logic [CNT_W-1:0] SECT_LOAD = CNT_W'(SECT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CHIP_LOAD = CNT_W'(CHIP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (op == OP_SECT) begin
      busy <= 1'b1;
      cnt  <= SECT_LOAD;
    end else if (op == OP_CHIP) begin
      busy <= 1'b1;
      cnt  <= CHIP_LOAD;
    end else if (expire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  p_erase_load_r2: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_SECT) || (op == OP_CHIP)) |=> busy);
  p_expire_ends_r6: assert property (@(posedge clk) disable iff (rst)
    expire |=> !busy);
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !expire) |=> busy);
  p_prog_no_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && op == OP_PROG) |=> !busy);
endmodule

// File: rtl/fbs_status_reg.sv
module fbs_status_reg
  import fbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic              prog_msb,
  input  logic              status_rd,
  input  logic              busy,
  input  logic              expire,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] status_nx;

  always_comb begin
    status_nx = status;
    unique case (op)
      OP_SECT, OP_CHIP: status_nx = '0;
      OP_PROG: begin
        status_nx           = '1;
        status_nx[DONE_BIT] = ~prog_msb;
      end
      default: begin
        if (busy && status_rd) status_nx[TOGGLE_BIT] = ~status[TOGGLE_BIT];
        if (expire)            status_nx[DONE_BIT]   = ~status[DONE_BIT];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= status_nx;
  end

  p_erase_clear_r2: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_SECT) || (op == OP_CHIP)) |=> (status == '0));
  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && status_rd) |=> (status[TOGGLE_BIT] != $past(status[TOGGLE_BIT])));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && op == OP_NONE) |=> $stable(status));
  p_bit7_flip_r6: assert property (@(posedge clk) disable iff (rst)
    expire |=> (status[DONE_BIT] != $past(status[DONE_BIT])));
  p_prog_word_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PROG) |=> (status[DONE_BIT] == !$past(prog_msb)));
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import fbs_pkg::*;
#(
  parameter int SECT_CYCLES = 25_000_000,
  parameter int CHIP_CYCLES = 250_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_prog,
  input  logic       start_sect,
  input  logic       start_chip,
  input  logic       prog_msb,
  input  logic       bypass_en,
  input  logic       status_rd,
  output logic [7:0] status_out,
  output logic       busy,
  output logic       done,
  output logic       done_bypass
);
  op_e  op;
  logic expire;
  logic finish_now;

  fbs_op_pick u_pick (
    .clk        (clk),
    .rst        (rst),
    .start_prog (start_prog),
    .start_sect (start_sect),
    .start_chip (start_chip),
    .busy       (busy),
    .op         (op)
  );

  fbs_erase_timer #(
    .SECT_CYCLES (SECT_CYCLES),
    .CHIP_CYCLES (CHIP_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .busy   (busy),
    .expire (expire)
  );

  fbs_status_reg u_status (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .prog_msb  (prog_msb),
    .status_rd (status_rd),
    .busy      (busy),
    .expire    (expire),
    .status    (status_out)
  );

  assign finish_now = expire || (op == OP_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      done_bypass <= 1'b0;
    end else begin
      done        <= finish_now;
      done_bypass <= finish_now && bypass_en;
    end
  end

  p_bypass_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    done_bypass |-> done);
  p_expire_done_r6: assert property (@(posedge clk) disable iff (rst)
    expire |=> (done && !busy));
endmodule

// File: tb/flash_busy_status_test.sv
`timescale 1ns/1ps
module flash_busy_status_test;
  localparam int SECT_N = 5;
  localparam int CHIP_N = 12;

  logic clk = 1'b0;
  logic rst;
  logic start_prog, start_sect, start_chip, prog_msb, bypass_en, status_rd;
  logic [7:0] status_out;
  logic busy, done, done_bypass;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_busy_status #(.SECT_CYCLES(SECT_N), .CHIP_CYCLES(CHIP_N)) uut (
    .clk(clk), .rst(rst), .start_prog(start_prog), .start_sect(start_sect),
    .start_chip(start_chip), .prog_msb(prog_msb), .bypass_en(bypass_en),
    .status_rd(status_rd), .status_out(status_out), .busy(busy),
    .done(done), .done_bypass(done_bypass)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in;
    start_prog = 0; start_sect = 0; start_chip = 0; status_rd = 0;
  endtask

  // pat: 0 no reads, 1 read every cycle, 2 read on odd cycles
  task automatic run_erase(input bit chip, input int pat, input bit byp,
                           input bit inject, input bit extra);
    int n = chip ? CHIP_N : SECT_N;
    bit b6 = 0;
    bypass_en = byp;
    if (chip) start_chip = 1; else start_sect = 1;
    if (extra) begin
      start_prog = 1; prog_msb = 0;
      if (chip) start_sect = 1;
    end
    tick;
    clear_in;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(status_out == 8'h00, extra ? "R10 status after combined start" : "R2 status cleared",
          status_out, 0);
    for (int j = 1; j <= n; j++) begin
      check(busy == 1'b1, chip ? "R5 busy held" : "R4 busy held", busy, 1);
      check(status_out == {1'b0, b6, 6'b0}, "R3 bit6 toggle", status_out, {1'b0, b6, 6'b0});
      clear_in;
      status_rd = (pat == 1) || (pat == 2 && (j % 2 == 1));
      if (status_rd) b6 = ~b6;
      if (inject && j == 2) begin
        start_prog = 1; start_sect = 1; start_chip = 1; prog_msb = 0;
      end
      tick;
    end
    clear_in;
    check(busy == 1'b0, chip ? "R5 busy length" : (extra ? "R10 sector over program" : "R4 busy length"),
          busy, 0);
    check(done == 1'b1, "R6 done at end", done, 1);
    check(done_bypass == byp, "R8 bypass return", done_bypass, byp);
    check(status_out == {1'b1, b6, 6'b0}, inject ? "R9 status kept" : "R6 bit7 flipped",
          status_out, {1'b1, b6, 6'b0});
    status_rd = 1;
    tick;
    clear_in;
    check(done == 1'b0 && done_bypass == 1'b0, "R6 done single cycle", {done, done_bypass}, 0);
    check(status_out == {1'b1, b6, 6'b0}, "R3 idle read no change", status_out, {1'b1, b6, 6'b0});
  endtask

  task automatic run_prog(input bit d, input bit byp);
    logic [7:0] e = {~d, 7'h7F};
    prog_msb = d; bypass_en = byp; start_prog = 1;
    tick;
    clear_in;
    check(busy == 1'b0, "R7 no busy on program", busy, 0);
    check(done == 1'b1, "R7 program done", done, 1);
    check(done_bypass == byp, "R8 program bypass", done_bypass, byp);
    check(status_out == e, "R7 program status", status_out, e);
    tick;
    check(done == 1'b0 && done_bypass == 1'b0, "R7 done single cycle", {done, done_bypass}, 0);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_in; prog_msb = 0; bypass_en = 0;
    rst = 1;
    tick; tick;
    rst = 0;
    check(status_out == 8'h00, "R1 reset status", status_out, 0);
    check({busy, done, done_bypass} == 3'b000, "R1 reset flags", {busy, done, done_bypass}, 0);
    tick;
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 3; p++)
        for (int b = 0; b < 2; b++)
          run_erase(c[0], p, b[0], 1'b0, 1'b0);
    run_erase(1'b1, 2, 1'b0, 1'b1, 1'b0);  // R9 chip with mid-run starts
    run_erase(1'b0, 1, 1'b1, 1'b1, 1'b0);  // R9 sector with mid-run starts
    run_erase(1'b1, 0, 1'b0, 1'b0, 1'b1);  // R10 chip over sector and program
    run_erase(1'b0, 2, 1'b0, 1'b0, 1'b1);  // R10 sector over program
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 2; b++)
        run_prog(d[0], b[0]);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule